// File: doc/BRIEF.md
# Three-Channel Motor PWM Generator

This block drives three half-bridge motor legs. One shared counter sets the PWM period for all three channels. Each channel compares that counter against its own duty value, and the result drives a high-side pin and a low-side pin. The counter can run as a sawtooth for edge-aligned PWM, or as a triangle for center-aligned PWM. A channel's pin pair can run complementary, with a programmable dead band between the two sides, or independent, where both pins follow the duty comparison.

Each pin has its own active level. Each pin can also be forced to a fixed level by an override. The block raises a one-cycle trigger at a programmable point in the counter sweep, so that ADC sampling can line up with the switching pattern. Software writes the configuration over a simple write-enable/address/data bus. The period, duty, alignment and trigger values are staged and move into use together at a period boundary.

Top module: `mcpwm_top`

## Requirements
- R1: After reset, every override-enable bit is 1 and every override value is 0, so all six pins sit at 0. The trigger output is 0.
- R2: In edge-aligned mode (CTRL address 0, bit 0 = 0), the counter runs from 0 to P and then returns to 0, where P is written at address 1. A period is P+1 cycles. The high-side active state lasts D cycles per period, where D is the channel's duty written at address 8+c. If D > P, it lasts the whole period.
- R3: In center-aligned mode (CTRL bit 0 = 1), the counter rises from 0 to P-1, holds for one cycle, falls back to 0 and holds again. A period is 2P cycles. The high-side active state lasts 2D cycles and is centered on counter value 0.
- R4: In complementary mode, the low side is the inverse of the duty comparison. After each transition of the comparison, both sides stay inactive for T cycles, where T is written at address 2. This gives high-side active D-T cycles, low-side active (period-D)-T cycles, and no cycle with both sides active.
- R5: CTRL bit c+1 = 1 puts channel c in independent mode. The low-side pin then carries the same active state as the high side, and no dead band is applied.
- R6: Polarity register at address 4: bit 2c is the high pin of channel c and bit 2c+1 is its low pin. A bit value of 1 makes that pin active-low. The change shows on the pin one cycle after the write.
- R7: Override-enable register at address 5 and override-value register at address 6 use the same bit positions as R6. An enabled pin shows its override value directly, ignoring both comparison and polarity. Other pins are not affected.
- R8: Period (address 1), duty values, trigger compare (address 3) and CTRL bit 0 are staged. They take effect only at the edge where the counter wraps back to 0 at the end of a period. Before that, writes to them do not change the pins.
- R9: The trigger output pulses for exactly one cycle when the counter equals the compare value (address 3) while counting up. That gives one pulse per period, and no pulses while the active period is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | CW (15) | Register write data |
| pwm_hi | output | NCH (3) | High-side pins, one per channel |
| pwm_lo | output | NCH (3) | Low-side pins, one per channel |
| adc_trig | output | 1 | One-cycle ADC start pulse |

## Verification
The bench builds the block with its defaults: three channels, a 15-bit counter and an 8-bit dead-time field. It programs periods of 10 cycles in both alignments, so each 20-cycle window holds exactly two periods. Every pin-activity count is therefore exact whatever the phase. A dead time of 2 makes the four idle cycles per period visible. A staged duty write lands mid-period, timed off the trigger pulse, which exposes any early load. A period of zero reaches the trigger-suppression corner.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  // register addresses
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_PERIOD  = 1;
  localparam int ADDR_DEAD    = 2;
  localparam int ADDR_TRIG    = 3;
  localparam int ADDR_POL     = 4;
  localparam int ADDR_OVR_EN  = 5;
  localparam int ADDR_OVR_VAL = 6;
  localparam int ADDR_DUTY0   = 8;

  // bit index of a pin in the polarity / override registers
  function automatic int hi_bit(input int ch);
    return 2 * ch;
  endfunction

  function automatic int lo_bit(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
  import mcpwm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 15,
  parameter int DTW = 8,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    wrap,
  output logic [CW-1:0]           per_act,
  output logic [CW-1:0]           trig_act,
  output logic                    center_act,
  output logic [NCH-1:0][CW-1:0]  duty_act,
  output logic [NCH-1:0]          indep,
  output logic [DTW-1:0]          dead,
  output logic [2*NCH-1:0]        pol,
  output logic [2*NCH-1:0]        ovr_en,
  output logic [2*NCH-1:0]        ovr_val
);
  localparam int NP = 2 * NCH;

  logic [CW-1:0] per_sh, trig_sh;
  logic          center_sh;

  // shared registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh     <= '0;
      trig_sh    <= '0;
      center_sh  <= 1'b0;
      per_act    <= '0;
      trig_act   <= '0;
      center_act <= 1'b0;
      indep      <= '0;
      dead       <= '0;
      pol        <= '0;
      ovr_en     <= '1;
      ovr_val    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          AW'(ADDR_CTRL): begin
            center_sh <= wr_data[0];
            indep     <= wr_data[NCH:1];
          end
          AW'(ADDR_PERIOD):  per_sh  <= wr_data;
          AW'(ADDR_DEAD):    dead    <= wr_data[DTW-1:0];
          AW'(ADDR_TRIG):    trig_sh <= wr_data;
          AW'(ADDR_POL):     pol     <= wr_data[NP-1:0];
          AW'(ADDR_OVR_EN):  ovr_en  <= wr_data[NP-1:0];
          AW'(ADDR_OVR_VAL): ovr_val <= wr_data[NP-1:0];
          default: ;
        endcase
      end
      // staged values move into use at the period boundary
      if (wrap) begin
        per_act    <= per_sh;
        trig_act   <= trig_sh;
        center_act <= center_sh;
      end
    end
  end

  // per-channel duty staging
  for (genvar c = 0; c < NCH; c++) begin : g_duty
    logic [CW-1:0] sh_q, act_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(ADDR_DUTY0 + c)) sh_q <= wr_data;
        if (wrap) act_q <= sh_q;
      end
    end
    assign duty_act[c] = act_q;
  end
endmodule

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] trig_act,
  input  logic          center_act,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          trig_hit
);
  typedef struct packed {
    logic          wrap;
    logic          up;
    logic [CW-1:0] cnt;
  } step_t;

  // one counter step for either alignment
  function automatic step_t step_fn(input logic [CW-1:0] c, input logic u,
                                    input logic [CW-1:0] p, input logic ctr);
    step_t s;
    s.wrap = 1'b0;
    s.up   = 1'b1;
    s.cnt  = c;
    if (!ctr) begin
      if (c >= p) begin
        s.cnt  = '0;
        s.wrap = 1'b1;
      end else begin
        s.cnt = c + 1'b1;
      end
    end else if (u) begin
      if (({1'b0, c} + (CW+1)'(1)) >= {1'b0, p}) s.up = 1'b0;   // hold at top
      else s.cnt = c + 1'b1;
    end else begin
      s.up = 1'b0;
      if (c == '0) begin                                          // hold at bottom
        s.up   = 1'b1;
        s.wrap = 1'b1;
      end else begin
        s.cnt = c - 1'b1;
      end
    end
    return s;
  endfunction

  logic  up;
  step_t nxt;

  assign nxt      = step_fn(cnt, up, per_act, center_act);
  assign wrap     = nxt.wrap;
  assign trig_hit = (cnt == trig_act) && up && (per_act != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= nxt.cnt;
      up  <= nxt.up;
    end
  end
endmodule

// File: rtl/mcpwm_deadband.sv
module mcpwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw,
  input  logic           indep,
  input  logic [DTW-1:0] dead,
  output logic           act_hi,
  output logic           act_lo
);
  logic           st;
  logic [DTW-1:0] tmr;
  logic           quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= 1'b0;
      tmr <= '0;
    end else if (raw != st) begin
      st  <= raw;
      tmr <= indep ? '0 : dead;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign quiet  = (tmr != '0) && !indep;
  assign act_hi = st && !quiet;
  assign act_lo = indep ? st : (!st && !quiet);
endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top
  import mcpwm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 15,
  parameter int DTW = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo,
  output logic           adc_trig
);
  localparam int NP = 2 * NCH;

  function automatic logic in_duty(input logic [CW-1:0] c, input logic [CW-1:0] d);
    return c < d;
  endfunction

  function automatic logic pin_level(input logic act, input logic pol_b,
                                     input logic oen, input logic oval);
    return oen ? oval : (act ^ pol_b);
  endfunction

  logic [CW-1:0]          per_act, trig_act, cnt;
  logic                   center_act, wrap, trig_hit;
  logic [NCH-1:0][CW-1:0] duty_act;
  logic [NCH-1:0]         indep, raw, act_hi, act_lo;
  logic [DTW-1:0]         dead;
  logic [NP-1:0]          pol, ovr_en, ovr_val;

  mcpwm_regs #(.NCH(NCH), .CW(CW), .DTW(DTW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .per_act(per_act), .trig_act(trig_act), .center_act(center_act),
    .duty_act(duty_act), .indep(indep), .dead(dead), .pol(pol),
    .ovr_en(ovr_en), .ovr_val(ovr_val)
  );

  mcpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_act(per_act), .trig_act(trig_act),
    .center_act(center_act), .cnt(cnt), .wrap(wrap), .trig_hit(trig_hit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign raw[c] = in_duty(cnt, duty_act[c]);

    mcpwm_deadband #(.DTW(DTW)) u_db (
      .clk(clk), .rst_n(rst_n), .raw(raw[c]), .indep(indep[c]), .dead(dead),
      .act_hi(act_hi[c]), .act_lo(act_lo[c])
    );

    assign pwm_hi[c] = pin_level(act_hi[c], pol[hi_bit(c)], ovr_en[hi_bit(c)], ovr_val[hi_bit(c)]);
    assign pwm_lo[c] = pin_level(act_lo[c], pol[lo_bit(c)], ovr_en[lo_bit(c)], ovr_val[lo_bit(c)]);
  end

  assign adc_trig = trig_hit;
endmodule

// File: rtl/mcpwm_chk.sv
module mcpwm_chk #(
  parameter int NCH = 3,
  parameter int CW  = 15,
  parameter int DTW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrap,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          per_act,
  input logic [NCH-1:0][CW-1:0] duty_act,
  input logic [NCH-1:0]         indep,
  input logic [DTW-1:0]         dead,
  input logic [NCH-1:0]         act_hi,
  input logic [NCH-1:0]         act_lo,
  input logic                   adc_trig
);
  a_r9_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  a_r8_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(per_act));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_act[c]));

    a_r4_dead_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(indep[c]) && ($past(dead) != '0) && $rose(act_hi[c])) |-> !$past(act_lo[c]));

    a_r4_dead_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(indep[c]) && ($past(dead) != '0) && $rose(act_lo[c])) |-> !$past(act_hi[c]));
  end
endmodule

bind mcpwm_top mcpwm_chk #(.NCH(NCH), .CW(CW), .DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt), .per_act(per_act),
  .duty_act(duty_act), .indep(indep), .dead(dead), .act_hi(act_hi),
  .act_lo(act_lo), .adc_trig(adc_trig)
);

// File: tb/mcpwm_top_tb.sv
module mcpwm_top_tb;
  localparam int NCH = 3;
  localparam int CW  = 15;
  localparam int AW  = 4;

  // register addresses as stated in the requirements
  localparam int A_CTRL = 0, A_PER = 1, A_DEAD = 2, A_TRIG = 3;
  localparam int A_POL = 4, A_OEN = 5, A_OVAL = 6, A_DUTY = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_hi, pwm_lo;
  logic           adc_trig;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_hi[NCH], m_lo[NCH], m_off[NCH], m_both[NCH], m_mis[NCH];
  int m_trig, m_gap, m_run;

  always #4 clk = ~clk;

  mcpwm_top #(.NCH(NCH), .CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .adc_trig(adc_trig)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // observe n cycles at falling edges
  task automatic measure(input int n);
    int last;
    int run;
    last = -1; run = 0;
    m_trig = 0; m_gap = 0; m_run = 0;
    for (int c = 0; c < NCH; c++) begin
      m_hi[c] = 0; m_lo[c] = 0; m_off[c] = 0; m_both[c] = 0; m_mis[c] = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        m_hi[c]   += int'(pwm_hi[c]);
        m_lo[c]   += int'(pwm_lo[c]);
        m_off[c]  += int'(!pwm_hi[c] && !pwm_lo[c]);
        m_both[c] += int'(pwm_hi[c] && pwm_lo[c]);
        m_mis[c]  += int'(pwm_hi[c] != pwm_lo[c]);
      end
      if (adc_trig) begin
        m_trig++;
        run++;
        if (last >= 0 && run == 1) m_gap = i - last;
        if (run == 1) last = i;
        if (run > m_run) m_run = run;
      end else begin
        run = 0;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "pwm_hi after reset", int'(pwm_hi), 0);
      chk("R1", "pwm_lo after reset", int'(pwm_lo), 0);
      chk("R1", "adc_trig after reset", int'(adc_trig), 0);
    end
  endtask

  task automatic t_edge;
    wr(A_PER, 9); wr(A_TRIG, 5);
    wr(A_DUTY + 0, 3); wr(A_DUTY + 1, 0); wr(A_DUTY + 2, 12);
    wr(A_OEN, 0);
    repeat (30) @(negedge clk);
    measure(20);
    chk("R2", "ch0 hi cycles", m_hi[0], 6);
    chk("R4", "ch0 lo cycles", m_lo[0], 14);
    chk("R2", "ch1 duty 0 hi cycles", m_hi[1], 0);
    chk("R4", "ch1 lo cycles", m_lo[1], 20);
    chk("R2", "ch2 duty above period hi cycles", m_hi[2], 20);
    chk("R4", "ch0 overlap", m_both[0], 0);
    chk("R9", "edge trigger count", m_trig, 2);
    chk("R9", "edge trigger spacing", m_gap, 10);
    chk("R9", "trigger width", m_run, 1);
  endtask

  task automatic t_buffer;
    int seen;
    seen = 0;
    for (int i = 0; i < 40 && seen == 0; i++) begin
      @(negedge clk);
      if (adc_trig) seen = 1;
    end
    chk("R8", "trigger seen for sync", seen, 1);
    wr_en = 1'b1; wr_addr = AW'(A_DUTY + 0); wr_data = CW'(7);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", "ch0 hi after staged write, cycle 0", int'(pwm_hi[0]), 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R8", "ch0 hi before boundary", int'(pwm_hi[0]), 0);
    end
    repeat (20) @(negedge clk);
    measure(20);
    chk("R8", "ch0 hi after boundary", m_hi[0], 14);
  endtask

  task automatic t_dead;
    wr(A_DUTY + 0, 5); wr(A_DEAD, 2);
    repeat (30) @(negedge clk);
    measure(20);
    chk("R4", "ch0 hi with dead band", m_hi[0], 6);
    chk("R4", "ch0 lo with dead band", m_lo[0], 6);
    chk("R4", "ch0 idle cycles", m_off[0], 8);
    chk("R4", "ch0 overlap", m_both[0], 0);
    chk("R4", "ch2 steady high", m_hi[2], 20);
  endtask

  task automatic t_indep;
    wr(A_DUTY + 1, 4); wr(A_CTRL, 32'h4);
    repeat (30) @(negedge clk);
    measure(20);
    chk("R5", "ch1 hi independent", m_hi[1], 8);
    chk("R5", "ch1 lo independent", m_lo[1], 8);
    chk("R5", "ch1 hi/lo mismatch", m_mis[1], 0);
    chk("R4", "ch0 still complementary", m_off[0], 8);
  endtask

  task automatic t_pol;
    wr(A_POL, 1);
    repeat (2) @(negedge clk);
    measure(20);
    chk("R6", "ch0 hi active-low", m_hi[0], 14);
    chk("R6", "ch0 lo unchanged", m_lo[0], 6);
  endtask

  task automatic t_ovr;
    wr(A_OVAL, 32'h20); wr(A_OEN, 32'h21);
    repeat (2) @(negedge clk);
    measure(20);
    chk("R7", "ch0 hi forced 0 over polarity", m_hi[0], 0);
    chk("R7", "ch2 lo forced 1", m_lo[2], 20);
    chk("R7", "ch0 lo unaffected", m_lo[0], 6);
    chk("R7", "ch2 hi unaffected", m_hi[2], 20);
    wr(A_OEN, 0); wr(A_POL, 0); wr(A_DEAD, 0); wr(A_CTRL, 0);
  endtask

  task automatic t_center;
    wr(A_CTRL, 1); wr(A_PER, 5); wr(A_TRIG, 3); wr(A_DUTY + 0, 2);
    repeat (40) @(negedge clk);
    measure(20);
    chk("R3", "center ch0 hi", m_hi[0], 8);
    chk("R3", "center ch0 lo", m_lo[0], 12);
    chk("R3", "center ch2 full", m_hi[2], 20);
    chk("R9", "center trigger count", m_trig, 2);
    chk("R3", "center period via trigger", m_gap, 10);
    chk("R9", "center trigger width", m_run, 1);
  endtask

  task automatic t_zero_period;
    wr(A_CTRL, 0); wr(A_PER, 0); wr(A_TRIG, 0);
    repeat (30) @(negedge clk);
    measure(20);
    chk("R9", "no trigger at period 0", m_trig, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge();
    t_buffer();
    t_dead();
    t_indep();
    t_pol();
    t_ovr();
    t_center();
    t_zero_period();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule